// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two 16-bit timer/counters. Each one is kept as a low count byte and a high count byte. A byte-wide register port configures both units through a mode byte and a control byte, and the same port reads back and overwrites every count byte. Each unit advances on an internal machine-cycle tick or on falling edges of its own external count pin. A unit can also be gated by the level of an external interrupt pin. When a unit rolls over it sets a sticky overflow flag. The flag is cleared by software or by an acknowledge pulse from the interrupt logic.

Each unit has four counting modes: a 13-bit counter with a 5-bit prescaler, a plain 16-bit counter, an 8-bit counter that reloads from the high byte, and a split mode. In split mode, timer 0 becomes two independent 8-bit counters, and the second of them takes over timer 1's run bit and flag. Every timer 1 rollover also produces a one-cycle baud tick that a serial port can use as its bit clock.

Top module: `dual_timer`

## Requirements
- R1: Register addresses: 0 is the mode byte, 1 the control byte, 2 and 3 the low and high bytes of timer 0, and 4 and 5 those of timer 1. Addresses 6 and 7 read 00h and ignore writes. In the mode byte, bits 3:0 configure timer 0 and bits 7:4 configure timer 1. Each nibble is {gate, external-source, mode[1:0]} from its top bit down. In the control byte, bit 7 is flag 1, bit 6 is run 1, bit 5 is flag 0 and bit 4 is run 0. Bits 3:0 of the control byte read 0 and ignore writes.
- R2: A unit advances only when its run bit is 1 and either its gate bit is 0 or its interrupt pin (after two synchroniser flops) is high.
- R3: With external-source 0 a unit counts cycles where `tick` is high. With external-source 1 it counts high-to-low transitions of its count pin. A pin value sampled at clock edge k is counted at edge k+2.
- R4: Mode 0: bits 4:0 of the low byte form a prescaler. When they pass 31 they wrap to 0 and the high byte increments. Low-byte bits 7:5 hold. The overflow is the high byte wrapping from FFh.
- R5: Mode 1: the two bytes form one 16-bit counter, and the overflow is the wrap from FFFFh to 0000h.
- R6: Mode 2: the low byte counts. On wrapping from FFh it loads the high byte, which never changes by counting, and the wrap is the overflow.
- R7: Timer 0 in mode 3: its low byte is an 8-bit counter under timer 0's run, gate and source bits, and sets flag 0. Its high byte counts `tick` under run 1 alone and sets flag 1 on wrapping from FFh.
- R8: While timer 0 is in mode 3, timer 1 ignores run 1 and never sets flag 1. Timer 1 in mode 3 holds its count.
- R9: A flag set by hardware appears one cycle after the rollover and beats an acknowledge or a software write in the same cycle. Otherwise `irq_ack[i]` clears flag i, and a control write loads it. `irq_ack` beats the write.
- R10: A write to a count byte loads that byte, overriding the increment of that byte in the same cycle.
- R11: `baud_tick` pulses for one cycle, one cycle after each timer 1 overflow.
- R12: Synchronous reset clears all registers, flags and `baud_tick` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | AW | register write address |
| wr_data | input | 8 | register write data |
| rd_addr | input | AW | register read address |
| rd_data | output | 8 | register read data (combinational) |
| tick | input | 1 | internal machine-cycle tick |
| cnt_pin | input | 2 | external count pins, one per unit (asynchronous) |
| gate_pin | input | 2 | external interrupt pin levels used for gating (asynchronous) |
| irq_ack | input | 2 | interrupt acknowledge, clears the matching flag |
| ovf_flag | output | 2 | sticky overflow flags |
| baud_tick | output | 1 | one-cycle pulse per timer 1 overflow |

## Verification
A wrong count, mode decode or run gating reaches the ports as a read value that differs from the model in the cycle after the faulty edge. The bench reads one register address every cycle, so a bad byte shows within eight cycles. A misrouted rollover, such as split-mode borrowing that goes to the wrong flag, appears on `ovf_flag` or `baud_tick` one cycle after the overflow edge. Synchroniser depth errors shift every external count by a cycle, and the per-cycle comparison catches that on the first counted edge.

// File: rtl/tc_pkg.sv
package tc_pkg;

    localparam int BYTE_W = 8;

    localparam int ADR_MODE = 0;
    localparam int ADR_CTRL = 1;
    localparam int ADR_CNT0 = 2;   // unit i low byte at ADR_CNT0 + 2*i, high byte next

    typedef enum logic [1:0] {
        TM_PRESCALED = 2'd0,
        TM_WIDE      = 2'd1,
        TM_RELOAD    = 2'd2,
        TM_SPLIT     = 2'd3
    } tmode_e;

    typedef struct packed {
        logic   gate;
        logic   ext_src;
        tmode_e mode;
    } tcfg_s;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } tcount_s;

    function automatic logic run_allowed(input tcfg_s cfg, input logic run, input logic pin);
        return run & (~cfg.gate | pin);
    endfunction

endpackage

// File: rtl/tc_sync.sv
module tc_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) st[k] <= '0;
        end else begin
            st[0] <= din;
            for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
        end
    end

    assign dout = st[STAGES-1];
endmodule

// File: rtl/tc_unit.sv
module tc_unit
    import tc_pkg::*;
#(
    parameter int PRE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  tmode_e            mode,
    input  logic              inc,
    input  logic              hi_inc,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output tcount_s           cnt,
    output logic              ovf,
    output logic              ovf_hi
);
    tcount_s nxt;

    always_comb begin
        nxt    = cnt;
        ovf    = 1'b0;
        ovf_hi = 1'b0;
        unique case (mode)
            TM_PRESCALED: if (inc) begin
                if (&cnt.lo[PRE_W-1:0]) begin
                    nxt.lo[PRE_W-1:0] = '0;
                    nxt.hi            = cnt.hi + 1'b1;
                    ovf               = &cnt.hi;
                end else begin
                    nxt.lo[PRE_W-1:0] = cnt.lo[PRE_W-1:0] + 1'b1;
                end
            end
            TM_WIDE: if (inc) begin
                nxt = tcount_s'(cnt + 1'b1);
                ovf = &cnt;
            end
            TM_RELOAD: if (inc) begin
                if (&cnt.lo) begin
                    nxt.lo = cnt.hi;
                    ovf    = 1'b1;
                end else begin
                    nxt.lo = cnt.lo + 1'b1;
                end
            end
            TM_SPLIT: begin
                if (inc) begin
                    nxt.lo = cnt.lo + 1'b1;
                    ovf    = &cnt.lo;
                end
                if (hi_inc) begin
                    nxt.hi = cnt.hi + 1'b1;
                    ovf_hi = &cnt.hi;
                end
            end
            default: ;
        endcase
        if (wr_lo) nxt.lo = wdata;
        if (wr_hi) nxt.hi = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= nxt;
    end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import tc_pkg::*;
#(
    parameter int AW          = 3,
    parameter int SYNC_STAGES = 2,
    parameter int PRE_W       = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              tick,
    input  logic [1:0]        cnt_pin,
    input  logic [1:0]        gate_pin,
    input  logic [1:0]        irq_ack,
    output logic [1:0]        ovf_flag,
    output logic              baud_tick
);
    localparam int NU = 2;
    localparam logic [AW-1:0] A_MODE = AW'(ADR_MODE);
    localparam logic [AW-1:0] A_CTRL = AW'(ADR_CTRL);

    logic [BYTE_W-1:0] mode_q;
    logic [NU-1:0]     run_q;
    logic [NU-1:0]     flag_q;
    logic              baud_q;

    logic [NU-1:0] cnt_s, cnt_prev, gate_s, fall;
    logic [NU-1:0] inc, hi_inc, ovf, ovf_hi, set_hw, run_eff;
    tcfg_s         cfg   [NU];
    tcount_s       cnt_w [NU];
    logic          split0;
    logic          ctrl_wr;

    tc_sync #(.N(NU), .STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst(rst), .din(cnt_pin), .dout(cnt_s));
    tc_sync #(.N(NU), .STAGES(SYNC_STAGES)) u_gate_sync (
        .clk(clk), .rst(rst), .din(gate_pin), .dout(gate_s));

    always_ff @(posedge clk) begin
        if (rst) cnt_prev <= '0;
        else     cnt_prev <= cnt_s;
    end
    assign fall = cnt_prev & ~cnt_s;

    assign split0     = (cfg[0].mode == TM_SPLIT);
    assign run_eff[0] = run_q[0];
    assign run_eff[1] = split0 | run_q[1];
    assign hi_inc[0]  = split0 & tick & run_q[1];
    assign hi_inc[1]  = 1'b0;
    assign ctrl_wr    = wr_en && (wr_addr == A_CTRL);

    for (genvar i = 0; i < NU; i++) begin : g_unit
        localparam logic [AW-1:0] A_LO = AW'(ADR_CNT0 + 2*i);
        localparam logic [AW-1:0] A_HI = AW'(ADR_CNT0 + 2*i + 1);
        logic ev;

        assign cfg[i] = tcfg_s'(mode_q[4*i +: 4]);
        assign ev     = cfg[i].ext_src ? fall[i] : tick;
        assign inc[i] = run_allowed(cfg[i], run_eff[i], gate_s[i]) & ev
                      & ((i == 0) || (cfg[i].mode != TM_SPLIT));

        tc_unit #(.PRE_W(PRE_W)) u_unit (
            .clk(clk), .rst(rst), .mode(cfg[i].mode),
            .inc(inc[i]), .hi_inc(hi_inc[i]),
            .wr_lo(wr_en && (wr_addr == A_LO)),
            .wr_hi(wr_en && (wr_addr == A_HI)),
            .wdata(wr_data), .cnt(cnt_w[i]),
            .ovf(ovf[i]), .ovf_hi(ovf_hi[i]));

        always_ff @(posedge clk) begin
            if (rst)             flag_q[i] <= 1'b0;
            else if (set_hw[i])  flag_q[i] <= 1'b1;
            else if (irq_ack[i]) flag_q[i] <= 1'b0;
            else if (ctrl_wr)    flag_q[i] <= wr_data[5 + 2*i];
        end
    end

    assign set_hw[0] = ovf[0];
    assign set_hw[1] = split0 ? ovf_hi[0] : (ovf[1] | ovf_hi[1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            run_q  <= '0;
            baud_q <= 1'b0;
        end else begin
            if (wr_en && (wr_addr == A_MODE)) mode_q <= wr_data;
            if (ctrl_wr) run_q <= {wr_data[6], wr_data[4]};
            baud_q <= ovf[1];
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_MODE:                       rd_data = mode_q;
            A_CTRL:                       rd_data = {flag_q[1], run_q[1], flag_q[0], run_q[0], 4'b0000};
            AW'(ADR_CNT0):                rd_data = cnt_w[0].lo;
            AW'(ADR_CNT0 + 1):            rd_data = cnt_w[0].hi;
            AW'(ADR_CNT0 + 2):            rd_data = cnt_w[1].lo;
            AW'(ADR_CNT0 + 3):            rd_data = cnt_w[1].hi;
            default:                      rd_data = '0;
        endcase
    end

    assign ovf_flag  = flag_q;
    assign baud_tick = baud_q;
endmodule

// File: rtl/tc_chk.sv
module tc_chk
    import tc_pkg::*;
#(
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [1:0]    irq_ack,
    input logic [1:0]    ovf_flag,
    input logic          baud_tick,
    input logic [7:0]    mode_q,
    input logic [1:0]    run_q,
    input tcount_s       t0_cnt,
    input tcount_s       t1_cnt,
    input logic [1:0]    set_hw
);
    logic wr_t0, wr_t1, wr_ctl;
    assign wr_t0  = wr_en && (wr_addr == AW'(ADR_CNT0) || wr_addr == AW'(ADR_CNT0 + 1));
    assign wr_t1  = wr_en && (wr_addr == AW'(ADR_CNT0 + 2) || wr_addr == AW'(ADR_CNT0 + 3));
    assign wr_ctl = wr_en && (wr_addr == AW'(ADR_CTRL));

    // R2: with both run bits low nothing moves timer 0 except a write
    p_stopped_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (run_q == 2'b00 && !wr_t0) |=> $stable(t0_cnt));

    // R8: timer 1 in mode 3 holds its count
    p_t1_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_q[5:4] == 2'b11 && !wr_t1) |=> $stable(t1_cnt));

    // R9: hardware set wins
    p_hw_set0_r9: assert property (@(posedge clk) disable iff (rst)
        set_hw[0] |=> ovf_flag[0]);
    p_hw_set1_r9: assert property (@(posedge clk) disable iff (rst)
        set_hw[1] |=> ovf_flag[1]);

    // R9: acknowledge clears when no set competes
    p_ack_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_ack[0] && !set_hw[0]) |=> !ovf_flag[0]);

    // R9: flag is sticky without ack or control write
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag[1] && !irq_ack[1] && !wr_ctl) |=> ovf_flag[1]);

    // R11: no baud tick from a frozen timer 1
    p_baud_src_r11: assert property (@(posedge clk) disable iff (rst)
        baud_tick |-> ($past(mode_q[5:4]) != 2'b11));

    // R12: reset clears flags and baud tick
    p_reset_clear_r12: assert property (@(posedge clk)
        rst |=> (ovf_flag == 2'b00 && !baud_tick));
endmodule

bind dual_timer tc_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .irq_ack(irq_ack), .ovf_flag(ovf_flag), .baud_tick(baud_tick),
    .mode_q(mode_q), .run_q(run_q), .t0_cnt(cnt_w[0]), .t1_cnt(cnt_w[1]),
    .set_hw(set_hw));

// File: tb/dual_timer_tb_top.sv
`timescale 1ns/1ps
module dual_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tick = 1'b0;
    logic [1:0] cnt_pin = '0;
    logic [1:0] gate_pin = '0;
    logic [1:0] irq_ack = '0;
    logic [1:0] ovf_flag;
    logic       baud_tick;

    always #2.5 clk = ~clk;

    dual_timer dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .irq_ack(irq_ack), .ovf_flag(ovf_flag), .baud_tick(baud_tick));

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    bit    dense = 1'b1;
    bit    rnd_pins = 1'b0;
    string cur_req = "R12";

    // behavioural reference state
    int m_mode, m_run0, m_run1, m_f0, m_f1, m_baud;
    int m_lo[2], m_hi[2];
    int cs1[2], cs2[2], cs3[2], gs1[2], gs2[2];

    task automatic count_step(input int md, input int inc, input int hinc,
                              inout int lo, inout int hi, output int ov, output int ovh);
        int v, p;
        ov = 0; ovh = 0;
        if (md == 1) begin
            if (inc != 0) begin
                v = hi * 256 + lo + 1;
                if (v == 65536) begin v = 0; ov = 1; end
                hi = v / 256; lo = v % 256;
            end
        end else if (md == 0) begin
            if (inc != 0) begin
                p = lo % 32 + 1;
                if (p == 32) begin
                    p = 0; hi = hi + 1;
                    if (hi == 256) begin hi = 0; ov = 1; end
                end
                lo = (lo / 32) * 32 + p;
            end
        end else if (md == 2) begin
            if (inc != 0) begin
                if (lo == 255) begin lo = hi; ov = 1; end
                else lo = lo + 1;
            end
        end else begin
            if (inc != 0) begin
                lo = lo + 1;
                if (lo == 256) begin lo = 0; ov = 1; end
            end
            if (hinc != 0) begin
                hi = hi + 1;
                if (hi == 256) begin hi = 0; ovh = 1; end
            end
        end
    endtask

    function automatic int model_rd(input int a);
        case (a)
            0: return m_mode;
            1: return m_f1 * 128 + m_run1 * 64 + m_f0 * 32 + m_run0 * 16;
            2: return m_lo[0];
            3: return m_hi[0];
            4: return m_lo[1];
            5: return m_hi[1];
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        int md[2], inc[2], ov[2], ovh[2];
        int fl, gt, ext, ev, rn, hinc, wa, wd, set1;
        if (rst) begin
            m_mode = 0; m_run0 = 0; m_run1 = 0; m_f0 = 0; m_f1 = 0; m_baud = 0;
            for (int i = 0; i < 2; i++) begin
                m_lo[i] = 0; m_hi[i] = 0;
                cs1[i] = 0; cs2[i] = 0; cs3[i] = 0; gs1[i] = 0; gs2[i] = 0;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                md[i] = (m_mode >> (4*i)) & 3;
                gt    = (m_mode >> (4*i + 3)) & 1;
                ext   = (m_mode >> (4*i + 2)) & 1;
                fl    = (cs3[i] == 1 && cs2[i] == 0) ? 1 : 0;
                ev    = ext ? fl : int'(tick);
                if (i == 0) rn = m_run0;
                else        rn = (md[0] == 3) ? 1 : m_run1;
                inc[i] = (rn != 0 && (gt == 0 || gs2[i] != 0) && ev != 0 && !(i == 1 && md[1] == 3)) ? 1 : 0;
            end
            hinc = (md[0] == 3 && tick && m_run1 != 0) ? 1 : 0;
            count_step(md[0], inc[0], hinc, m_lo[0], m_hi[0], ov[0], ovh[0]);
            count_step(md[1], inc[1], 0,    m_lo[1], m_hi[1], ov[1], ovh[1]);
            set1 = (md[0] == 3) ? ovh[0] : ov[1];
            wa = int'(wr_addr); wd = int'(wr_data);
            if (ov[0] != 0)          m_f0 = 1;
            else if (irq_ack[0])     m_f0 = 0;
            else if (wr_en && wa==1) m_f0 = (wd >> 5) & 1;
            if (set1 != 0)           m_f1 = 1;
            else if (irq_ack[1])     m_f1 = 0;
            else if (wr_en && wa==1) m_f1 = (wd >> 7) & 1;
            if (wr_en) begin
                case (wa)
                    0: m_mode = wd;
                    1: begin m_run0 = (wd >> 4) & 1; m_run1 = (wd >> 6) & 1; end
                    2: m_lo[0] = wd;
                    3: m_hi[0] = wd;
                    4: m_lo[1] = wd;
                    5: m_hi[1] = wd;
                    default: ;
                endcase
            end
            m_baud = ov[1];
            for (int i = 0; i < 2; i++) begin
                cs3[i] = cs2[i]; cs2[i] = cs1[i]; cs1[i] = int'(cnt_pin[i]);
                gs2[i] = gs1[i]; gs1[i] = int'(gate_pin[i]);
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("flag0", int'(ovf_flag[0]), m_f0);
            chk("flag1", int'(ovf_flag[1]), m_f1);
            chk("baud_tick", int'(baud_tick), m_baud);
            chk($sformatf("rd[%0d]", rd_addr), int'(rd_data), model_rd(int'(rd_addr)));
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
        wr_en = 1'b0; irq_ack = '0;
        rd_addr = rd_addr + 1'b1;
        tick = dense ? 1'b1 : 1'($urandom_range(0, 1));
        if (rnd_pins) begin
            cnt_pin  = 2'($urandom_range(0, 3));
            gate_pin = 2'($urandom_range(0, 3));
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        cyc();
    endtask

    task automatic run_n(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin : stim
        tick = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R12: reset state
        cur_req = "R12";
        chk("ovf_flag after reset", int'(ovf_flag), 0);
        run_n(8);

        // R1: low control nibble and unused addresses ignore writes
        cur_req = "R1";
        wr(1, 8'h0F); wr(6, 8'h77); wr(7, 8'h12);
        wr(0, 8'hA5); run_n(8); wr(0, 8'h00);
        run_n(8);
        chk("ctrl low nibble", model_rd(1) & 15, 0);

        // R5: 16-bit wrap
        cur_req = "R5";
        wr(0, 8'h01); wr(2, 8'hFE); wr(3, 8'hFF); wr(1, 8'h10);
        run_n(5);
        chk("flag0 after 16-bit wrap", int'(ovf_flag[0]), 1);
        wr(1, 8'h00);

        // R4: prescaled 13-bit wrap, low bits 7:5 hold
        cur_req = "R4";
        wr(0, 8'h00); wr(2, 8'hFE); wr(3, 8'hFF); wr(1, 8'h10);
        run_n(6);
        chk("flag0 after prescaled wrap", int'(ovf_flag[0]), 1);
        wr(1, 8'h00);
        run_n(8);

        // R6 / R11: auto-reload on timer 1 with baud ticks
        cur_req = "R6";
        wr(0, 8'h20); wr(5, 8'hF0); wr(4, 8'hFE); wr(1, 8'h40);
        run_n(40);
        chk("flag1 after reload", int'(ovf_flag[1]), 1);
        cur_req = "R11";
        run_n(20);
        wr(1, 8'h00);

        // R7: split mode, high byte uses run 1 and flag 1
        cur_req = "R7";
        wr(0, 8'h03); wr(3, 8'hFD); wr(2, 8'hF0); wr(1, 8'h50);
        run_n(30);
        chk("flag1 from split high byte", int'(ovf_flag[1]), 1);
        chk("flag0 from split low byte", int'(ovf_flag[0]), 1);
        wr(1, 8'h00);

        // R8: timer 1 ignores run 1 under split; frozen in mode 3
        cur_req = "R8";
        wr(0, 8'h13); wr(4, 8'hFA); wr(5, 8'hFF);
        run_n(16);
        wr(0, 8'h30); wr(1, 8'h40);
        run_n(16);
        wr(1, 8'h00);

        // R2: gating by interrupt pin
        cur_req = "R2";
        gate_pin = 2'b00;
        wr(0, 8'h09); wr(2, 8'h00); wr(3, 8'h00); wr(1, 8'h10);
        run_n(10);
        gate_pin = 2'b01;
        run_n(10);
        wr(1, 8'h00);

        // R3: external falling edges
        cur_req = "R3";
        wr(0, 8'h05); wr(1, 8'h10);
        for (int k = 0; k < 6; k++) begin
            cnt_pin[0] = 1'b1; run_n(3);
            cnt_pin[0] = 1'b0; run_n(2 + k);
        end
        wr(1, 8'h00);

        // R9: ack clears, hardware set beats ack and write
        cur_req = "R9";
        wr(0, 8'h01); wr(2, 8'hFF); wr(3, 8'hFF);
        wr(1, 8'h10);            // overflow occurs at the next edge
        irq_ack = 2'b01; wr(1, 8'h10);
        chk("flag0 set beats ack", int'(ovf_flag[0]), 1);
        irq_ack = 2'b01; cyc();
        chk("flag0 cleared by ack", int'(ovf_flag[0]), 0);
        wr(1, 8'hB0); run_n(2);
        wr(1, 8'h00); run_n(2);

        // R10: write beats increment
        cur_req = "R10";
        wr(0, 8'h01); wr(1, 8'h10);
        run_n(3); wr(2, 8'h55); run_n(3); wr(3, 8'hAA); run_n(3);
        wr(1, 8'h00);

        // mixed random traffic compared every cycle against the model
        cur_req = "R9";
        dense = 1'b0; rnd_pins = 1'b1;
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 5) == 0) begin
                wr_en = 1'b1;
                wr_addr = 3'($urandom_range(0, 7));
                wr_data = 8'($urandom_range(0, 255));
            end
            if ($urandom_range(0, 7) == 0) irq_ack = 2'($urandom_range(1, 3));
            cyc();
        end
        finish_run();
    end
endmodule